// File: doc/BRIEF.md
# Clocked Serial Shift Port with Address Wake-Up

This block moves one byte at a time over a synchronous serial link. A 5-bit mode register selects where the serial clock comes from, whether the link uses separate data-in and data-out pins (three-wire) or one shared open-drain data line (two-wire), the bit order in three-wire mode, and an address wake-up option. When an internal clock source is selected, writing the shift register starts a transfer. The block then drives eight clock periods. Output data changes on each falling serial edge, and input data is sampled on each rising edge. When the external clock is selected, the block follows edges arriving on the clock pin.

When wake-up is off, a one-cycle interrupt pulse follows every completed byte. When wake-up is on, the block leaves the data line undriven. It raises the interrupt only when the first byte received after a bus-release strobe equals the slave-address register. A busy indication is set by a strobe and released on command, but the release takes effect only on the next falling serial clock edge. In two-wire mode, busy also holds the data line low.

The controller is a four-state machine. ST_IDLE waits. It goes to ST_EXT when the external clock is selected, or to ST_RUN when the shift register is written with an internal source. ST_RUN and ST_EXT go to ST_CMP on the eighth rising edge. ST_EXT returns to ST_IDLE if an internal source is selected. ST_CMP always returns to ST_IDLE, and it is the state in which the interrupt is decided.

Top module: `sync_shift_port`

## Requirements
- R1: After reset, the mode register is 0 (external clock, three-wire, MSB-first, wake-up off). sck_out is 1, sck_oe is 0, and irq, busy_o and sda_pull are 0. sdo_oe is 1 and data_rdata is 0.
- R2: Mode bits [1:0] select the clock: 0 is external, 1 is the timer pulse, 2 is the system clock divided by DIV_SLOW (16), and 3 is the system clock divided by DIV_FAST (8). With an internal divider, consecutive falling edges of sck_out are exactly that many cycles apart, and exactly 8 falling edges occur per transfer.
- R3: sck_oe is 1 for every internal clock source and 0 for the external one. While sck_oe is 0, sck_out stays 1.
- R4: In three-wire mode (mode bit [2] = 0), mode bit [3] selects the order: 0 sends and receives MSB-first, 1 sends and receives LSB-first. sdo changes on the falling edge and sdi is sampled on the rising edge. After a transfer, data_rdata holds the byte received in that order.
- R5: In two-wire mode (bit [2] = 1), the transfer is always MSB-first, whatever bit [3] holds. A 0 bit asserts sda_pull, a 1 bit leaves the line released, and input is read from sda_in. sda_pull is never asserted in three-wire mode.
- R6: With wake-up off (bit [4] = 0), irq pulses for exactly one cycle after every completed 8-bit transfer, in every mode and for every clock source.
- R7: With wake-up on, irq pulses only if the first byte completed after a bus_release strobe equals the slave-address register. Later bytes raise no irq. sda_pull stays 0 unless busy is set.
- R8: busy_set asserts busy_o. After busy_rel, busy_o stays 1 until the next falling serial clock edge. Enabling wake-up does not release busy.
- R9: A write to the shift register while an internally clocked transfer is running is ignored.
- R10: With the timer source, each timer_tick pulse during a transfer produces one serial clock edge, so a transfer completes after 16 pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Mode register write strobe |
| cfg_wdata | input | 5 | Mode value: [4] wake-up, [3] LSB-first, [2] two-wire, [1:0] clock select |
| sar_we | input | 1 | Slave-address register write strobe |
| sar_wdata | input | 8 | Slave-address value |
| data_we | input | 1 | Shift register write strobe; starts an internal transfer |
| data_wdata | input | 8 | Byte to transmit |
| data_rdata | output | 8 | Shift register contents |
| timer_tick | input | 1 | Timer output pulse used as a clock source |
| bus_release | input | 1 | Strobe marking a bus release; arms the address compare |
| busy_set | input | 1 | Strobe asserting busy |
| busy_rel | input | 1 | Strobe requesting busy release |
| busy_o | output | 1 | Busy indication |
| sck_in | input | 1 | Serial clock pin input |
| sck_out | output | 1 | Serial clock pin output value |
| sck_oe | output | 1 | Serial clock pin output enable |
| sdi | input | 1 | Three-wire data input |
| sdo | output | 1 | Three-wire data output |
| sdo_oe | output | 1 | Three-wire push-pull output enable |
| sda_in | input | 1 | Two-wire data line sensed level |
| sda_pull | output | 1 | Two-wire open-drain drive-low enable |
| irq | output | 1 | One-cycle transfer-complete interrupt |

## Verification
A wrong bit count or a lost clock edge shows at the ports within one byte time. Either sck_out produces a number of falling edges other than eight, or irq arrives early, late or never, and data_rdata holds a shifted byte. A stuck bit-order or mode state corrupts the observed sdo or sda_pull sequence on the very first falling edge. A wrongly held wake-up state shows up as a missing or spurious irq on the first byte after bus_release. A busy release that is not tied to a falling edge changes busy_o while sck_out is still high.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

    typedef enum logic [1:0] {
        CK_EXT = 2'd0,
        CK_TMR = 2'd1,
        CK_D16 = 2'd2,
        CK_D8  = 2'd3
    } ck_sel_e;

    typedef struct packed {
        logic    wake;
        logic    lsb;
        logic    two_wire;
        ck_sel_e sel;
    } mode_t;

    localparam int MODE_W = $bits(mode_t);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_EXT,
        ST_CMP
    } st_e;

endpackage

// File: rtl/ssp_clkgen.sv
module ssp_clkgen
    import ssp_pkg::*;
#(
    parameter int DIV_SLOW = 16,
    parameter int DIV_FAST = 8
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    run,
    input  logic    ext_en,
    input  ck_sel_e sel,
    input  logic    timer_tick,
    input  logic    sck_in,
    output logic    sck_int,
    output logic    fall_ev,
    output logic    rise_ev
);
    localparam int HS = DIV_SLOW / 2;
    localparam int HF = DIV_FAST / 2;
    localparam int PW = $clog2(HS) + 1;

    logic [PW-1:0] pre_q;
    logic [2:0]    sync_q;
    logic          tick;
    logic          wrap;

    // source select: a tick toggles the internal serial clock
    always_comb begin
        unique case (sel)
            CK_EXT: begin
                wrap = 1'b0;
                tick = 1'b0;
            end
            CK_TMR: begin
                wrap = 1'b0;
                tick = timer_tick;
            end
            CK_D16: begin
                wrap = (pre_q == PW'(HS - 1));
                tick = wrap;
            end
            CK_D8: begin
                wrap = (pre_q == PW'(HF - 1));
                tick = wrap;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q   <= '0;
            sck_int <= 1'b1;
            sync_q  <= 3'b111;
        end else begin
            sync_q <= {sync_q[1:0], sck_in};
            if (!run) begin
                pre_q   <= '0;
                sck_int <= 1'b1;
            end else begin
                pre_q <= wrap ? '0 : pre_q + PW'(1);
                if (tick) begin
                    sck_int <= ~sck_int;
                end
            end
        end
    end

    always_comb begin
        if (run) begin
            fall_ev = tick & sck_int;
            rise_ev = tick & ~sck_int;
        end else begin
            fall_ev = ext_en & sync_q[2] & ~sync_q[1];
            rise_ev = ext_en & ~sync_q[2] & sync_q[1];
        end
    end

endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_data,
    input  logic         clr_cnt,
    input  logic         fall_ev,
    input  logic         rise_ev,
    input  logic         lsb,
    input  logic         din,
    output logic [W-1:0] shreg,
    output logic         out_bit,
    output logic         done_ev
);
    localparam int CW = $clog2(W);

    logic [CW-1:0] cnt_q;
    logic          last_bit;

    assign last_bit = (cnt_q == CW'(W - 1));
    assign done_ev  = rise_ev & last_bit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg   <= '0;
            cnt_q   <= '0;
            out_bit <= 1'b1;
        end else if (load) begin
            shreg   <= load_data;
            cnt_q   <= '0;
            out_bit <= 1'b1;
        end else begin
            // present the next bit on the falling edge
            if (fall_ev) begin
                out_bit <= lsb ? shreg[0] : shreg[W-1];
            end
            // sample on the rising edge
            if (rise_ev) begin
                shreg <= lsb ? {din, shreg[W-1:1]} : {shreg[W-2:0], din};
                cnt_q <= cnt_q + CW'(1);
                if (last_bit) begin
                    out_bit <= 1'b1;
                end
            end
            if (clr_cnt) begin
                cnt_q <= '0;
            end
        end
    end

endmodule

// File: rtl/ssp_busy.sv
module ssp_busy (
    input  logic clk,
    input  logic rst_n,
    input  logic busy_set,
    input  logic busy_rel,
    input  logic fall_ev,
    output logic busy
);
    logic rel_pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy       <= 1'b0;
            rel_pend_q <= 1'b0;
        end else if (busy_set) begin
            busy       <= 1'b1;
            rel_pend_q <= 1'b0;
        end else begin
            if (busy_rel && busy) begin
                rel_pend_q <= 1'b1;
            end
            // a pending release takes effect only at a falling serial edge
            if (fall_ev && rel_pend_q) begin
                busy       <= 1'b0;
                rel_pend_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/sync_shift_port.sv
module sync_shift_port
    import ssp_pkg::*;
#(
    parameter int W        = 8,
    parameter int DIV_SLOW = 16,
    parameter int DIV_FAST = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [MODE_W-1:0] cfg_wdata,
    input  logic              sar_we,
    input  logic [W-1:0]      sar_wdata,
    input  logic              data_we,
    input  logic [W-1:0]      data_wdata,
    output logic [W-1:0]      data_rdata,
    input  logic              timer_tick,
    input  logic              bus_release,
    input  logic              busy_set,
    input  logic              busy_rel,
    output logic              busy_o,
    input  logic              sck_in,
    output logic              sck_out,
    output logic              sck_oe,
    input  logic              sdi,
    output logic              sdo,
    output logic              sdo_oe,
    input  logic              sda_in,
    output logic              sda_pull,
    output logic              irq
);
    mode_t         mode_q;
    logic [W-1:0]  sar_q;
    logic          addr_pend_q;
    st_e           state_q;
    st_e           state_d;

    logic          ext_sel;
    logic          in_run;
    logic          in_ext;
    logic          fall_ev;
    logic          rise_ev;
    logic          done_ev;
    logic          out_bit;
    logic          load;
    logic          eff_lsb;
    logic          din;
    logic          addr_hit;

    assign ext_sel = (mode_q.sel == CK_EXT);
    assign in_run  = (state_q == ST_RUN);
    assign in_ext  = (state_q == ST_EXT);
    assign eff_lsb = mode_q.lsb & ~mode_q.two_wire;
    assign din     = mode_q.two_wire ? sda_in : sdi;
    assign load    = data_we & ((state_q == ST_IDLE) | in_ext);
    assign addr_hit = addr_pend_q & (data_rdata == sar_q);

    // configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q      <= '0;
            sar_q       <= '0;
            addr_pend_q <= 1'b0;
        end else begin
            if (cfg_we) begin
                mode_q <= mode_t'(cfg_wdata);
            end
            if (sar_we) begin
                sar_q <= sar_wdata;
            end
            if (bus_release) begin
                addr_pend_q <= 1'b1;
            end else if (state_q == ST_CMP) begin
                addr_pend_q <= 1'b0;
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (ext_sel) begin
                    state_d = ST_EXT;
                end else if (data_we) begin
                    state_d = ST_RUN;
                end
            end
            ST_RUN: begin
                if (done_ev) begin
                    state_d = ST_CMP;
                end
            end
            ST_EXT: begin
                if (!ext_sel) begin
                    state_d = ST_IDLE;
                end else if (done_ev) begin
                    state_d = ST_CMP;
                end
            end
            ST_CMP: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // outputs
    always_comb begin
        irq = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_RUN, ST_EXT: irq = 1'b0;
            ST_CMP:  irq = mode_q.wake ? addr_hit : 1'b1;
        endcase
        sck_oe   = ~ext_sel;
        sdo      = out_bit;
        sdo_oe   = ~mode_q.two_wire;
        sda_pull = mode_q.two_wire & (busy_o | (~mode_q.wake & ~out_bit));
    end

    ssp_clkgen #(
        .DIV_SLOW (DIV_SLOW),
        .DIV_FAST (DIV_FAST)
    ) u_clk (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (in_run),
        .ext_en     (in_ext),
        .sel        (mode_q.sel),
        .timer_tick (timer_tick),
        .sck_in     (sck_in),
        .sck_int    (sck_out),
        .fall_ev    (fall_ev),
        .rise_ev    (rise_ev)
    );

    ssp_shifter #(
        .W (W)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_data (data_wdata),
        .clr_cnt   (bus_release | cfg_we),
        .fall_ev   (fall_ev),
        .rise_ev   (rise_ev),
        .lsb       (eff_lsb),
        .din       (din),
        .shreg     (data_rdata),
        .out_bit   (out_bit),
        .done_ev   (done_ev)
    );

    ssp_busy u_busy (
        .clk      (clk),
        .rst_n    (rst_n),
        .busy_set (busy_set),
        .busy_rel (busy_rel),
        .fall_ev  (fall_ev),
        .busy     (busy_o)
    );

endmodule

// File: rtl/ssp_checker.sv
module ssp_checker (
    input logic clk,
    input logic rst_n,
    input logic irq,
    input logic busy,
    input logic sck_out,
    input logic sck_oe,
    input logic sda_pull,
    input logic two_wire,
    input logic wake
);
    // R6: the interrupt is a single-cycle pulse
    a_r6_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R3: with the external source the clock output rests high
    a_r3_ext_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !sck_oe |-> sck_out);

    // R5: three-wire mode never pulls the shared line
    a_r5_three_no_pull: assert property (@(posedge clk) disable iff (!rst_n)
        !two_wire |-> !sda_pull);

    // R7: in wake-up the line is only pulled for busy
    a_r7_wake_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (wake && !busy) |-> !sda_pull);

    // R8: busy drops only together with a falling serial edge
    a_r8_busy_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && sck_oe && $past(sck_oe)) |-> $fell(sck_out));

endmodule

bind sync_shift_port ssp_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq      (irq),
    .busy     (busy_o),
    .sck_out  (sck_out),
    .sck_oe   (sck_oe),
    .sda_pull (sda_pull),
    .two_wire (mode_q.two_wire),
    .wake     (mode_q.wake)
);

// File: tb/tb_sync_shift_port.sv
`timescale 1ns/1ps
module tb_sync_shift_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [4:0] cfg_wdata = '0;
    logic       sar_we = 1'b0;
    logic [7:0] sar_wdata = '0;
    logic       data_we = 1'b0;
    logic [7:0] data_wdata = '0;
    logic [7:0] data_rdata;
    logic       timer_tick = 1'b0;
    logic       bus_release = 1'b0;
    logic       busy_set = 1'b0;
    logic       busy_rel = 1'b0;
    logic       busy_o;
    logic       sck_in = 1'b1;
    logic       sck_out;
    logic       sck_oe;
    logic       sdi = 1'b1;
    logic       sdo;
    logic       sdo_oe;
    logic       sda_in = 1'b1;
    logic       sda_pull;
    logic       irq;

    int checks = 0;
    int errors = 0;
    int irq_seen = 0;
    int cyc = 0;
    bit done = 0;

    sync_shift_port dut (.*);

    always #5 clk = ~clk;

    always @(negedge clk) begin
        cyc++;
        if (irq) irq_seen++;
        if (cyc > 150000 && !done) begin
            errors++;
            $display("FAIL watchdog actual %0d expected below 150000", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wcfg(input logic [4:0] v);
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic pulse_rel();
        @(negedge clk); bus_release = 1'b1;
        @(negedge clk); bus_release = 1'b0;
    endtask

    // bench models of the expected results
    function automatic logic eff_lsb(input logic [4:0] cfg);
        return cfg[3] & ~cfg[2];
    endfunction

    function automatic logic [7:0] exp_rx(input logic [4:0] cfg, input logic [7:0] tx, input logic [7:0] rx);
        return cfg[2] ? (tx & rx) : rx;
    endfunction

    function automatic int exp_period(input logic [1:0] sel);
        return (sel == 2'd2) ? 16 : (sel == 2'd3) ? 8 : 6;
    endfunction

    task automatic xfer(input logic [4:0] cfg, input logic [7:0] tx, input logic [7:0] rx,
                        input bit mid, output logic [7:0] gtx, output int falls,
                        output int per, output int nirq);
        int start_irq;
        int last_fall;
        logic prev;
        bit bb;
        wcfg(cfg);
        @(negedge clk); data_we = 1'b1; data_wdata = tx;
        @(negedge clk); data_we = 1'b0;
        start_irq = irq_seen;
        falls = 0; per = 0; gtx = '0; prev = 1'b1; bb = 1'b1; last_fall = 0;
        for (int c = 0; c < 3000 && irq_seen == start_irq; c++) begin
            @(negedge clk);
            data_we = 1'b0;
            timer_tick = (cfg[1:0] == 2'd1) && (c % 3 == 0);
            if (prev && !sck_out && falls < 8) begin
                bb = eff_lsb(cfg) ? rx[falls] : rx[7 - falls];
                gtx[eff_lsb(cfg) ? falls : 7 - falls] = cfg[2] ? ~sda_pull : sdo;
                if (falls > 0) per = c - last_fall;
                last_fall = c;
                falls++;
                sdi = bb;
                if (mid && falls == 3) begin
                    data_we = 1'b1;
                    data_wdata = ~tx;
                end
            end
            prev = sck_out;
            sda_in = cfg[2] ? (~sda_pull & bb) : 1'b1;
        end
        timer_tick = 1'b0;
        data_we = 1'b0;
        repeat (3) @(negedge clk);
        sda_in = 1'b1;
        nirq = irq_seen - start_irq;
    endtask

    task automatic ext_byte(input logic [7:0] b, output bit pulled);
        pulled = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); sck_in = 1'b0; sda_in = b[7 - i]; sdi = b[7 - i];
            repeat (4) begin @(negedge clk); pulled |= sda_pull; end
            sck_in = 1'b1;
            repeat (4) begin @(negedge clk); pulled |= sda_pull; end
        end
        repeat (8) @(negedge clk);
        sda_in = 1'b1;
    endtask

    initial begin
        logic [7:0] gtx;
        int falls, per, nirq, base;
        bit pulled;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 sck_out", sck_out, 1);
        chk("R1 sck_oe", sck_oe, 0);
        chk("R1 irq", irq, 0);
        chk("R1 busy", busy_o, 0);
        chk("R1 sda_pull", sda_pull, 0);
        chk("R1 sdo_oe", sdo_oe, 1);
        chk("R1 rdata", data_rdata, 0);

        // directed: three-wire MSB and LSB at both dividers
        xfer(5'b00011, 8'hA5, 8'h3C, 0, gtx, falls, per, nirq);
        chk("R4 msb tx", gtx, 8'hA5); chk("R4 msb rx", data_rdata, 8'h3C);
        chk("R2 div8 period", per, 8); chk("R2 falls", falls, 8);
        chk("R3 oe internal", sck_oe, 1); chk("R6 irq once", nirq, 1);
        xfer(5'b01010, 8'h81, 8'h17, 0, gtx, falls, per, nirq);
        chk("R4 lsb tx", gtx, 8'h81); chk("R4 lsb rx", data_rdata, 8'h17);
        chk("R2 div16 period", per, 16);
        // R5 two-wire ignores the order bit
        xfer(5'b01110, 8'hC1, 8'hFF, 0, gtx, falls, per, nirq);
        chk("R5 two-wire tx msb", gtx, 8'hC1); chk("R5 two-wire rx", data_rdata, 8'hC1);
        // R10 timer source
        xfer(5'b00001, 8'h6E, 8'h92, 0, gtx, falls, per, nirq);
        chk("R10 timer falls", falls, 8); chk("R10 timer rx", data_rdata, 8'h92);
        chk("R10 timer period", per, 6); chk("R6 timer irq", nirq, 1);
        // R9 write during a running transfer
        xfer(5'b00011, 8'h4D, 8'hE2, 1, gtx, falls, per, nirq);
        chk("R9 tx kept", gtx, 8'h4D); chk("R9 rx kept", data_rdata, 8'hE2);

        // random transfers
        for (int n = 0; n < 24; n++) begin
            logic [4:0] cfg;
            logic [7:0] tx, rx;
            cfg = {1'b0, 1'($urandom), 1'($urandom), ($urandom % 3 == 0) ? 2'd1 : 2'(2 + $urandom % 2)};
            tx = 8'($urandom); rx = 8'($urandom);
            xfer(cfg, tx, rx, 0, gtx, falls, per, nirq);
            chk(cfg[2] ? "R5 rand tx" : "R4 rand tx", gtx, tx);
            chk(cfg[2] ? "R5 rand rx" : "R4 rand rx", data_rdata, exp_rx(cfg, tx, rx));
            chk("R2 rand period", per, exp_period(cfg[1:0]));
            chk("R6 rand irq", nirq, 1);
        end

        // external clock, three-wire, wake-up off
        wcfg(5'b00000);
        repeat (2) @(negedge clk);
        chk("R3 oe external", sck_oe, 0);
        base = irq_seen;
        ext_byte(8'h5B, pulled);
        chk("R6 ext irq", irq_seen - base, 1); chk("R4 ext rx", data_rdata, 8'h5B);

        // wake-up, two-wire, external clock
        @(negedge clk); sar_we = 1'b1; sar_wdata = 8'hA6;
        @(negedge clk); sar_we = 1'b0;
        wcfg(5'b10100);
        pulse_rel();
        base = irq_seen;
        ext_byte(8'hA6, pulled);
        chk("R7 match irq", irq_seen - base, 1); chk("R7 line released", pulled, 0);
        base = irq_seen;
        ext_byte(8'hA6, pulled);
        chk("R7 second byte no irq", irq_seen - base, 0);
        pulse_rel();
        base = irq_seen;
        ext_byte(8'hA7, pulled);
        chk("R7 mismatch no irq", irq_seen - base, 0); chk("R7 line released 2", pulled, 0);

        // busy hold and release on the falling serial edge
        wcfg(5'b00111);
        @(negedge clk); busy_set = 1'b1;
        @(negedge clk); busy_set = 1'b0;
        chk("R8 busy set", busy_o, 1); chk("R8 busy pulls line", sda_pull, 1);
        wcfg(5'b10111);
        repeat (3) @(negedge clk);
        chk("R8 wake keeps busy", busy_o, 1);
        @(negedge clk); busy_rel = 1'b1;
        @(negedge clk); busy_rel = 1'b0;
        repeat (5) @(negedge clk);
        chk("R8 busy held before edge", busy_o, 1);
        base = irq_seen;
        @(negedge clk); data_we = 1'b1; data_wdata = 8'h00;
        @(negedge clk); data_we = 1'b0;
        begin
            logic prev_busy;
            prev_busy = busy_o;
            for (int c = 0; c < 100 && sck_out; c++) begin
                prev_busy = busy_o;
                @(negedge clk);
            end
            chk("R8 busy before fall", prev_busy, 1);
            chk("R8 busy clears at fall", busy_o, 0);
        end
        repeat (120) @(negedge clk);
        chk("R7 no irq without release", irq_seen - base, 0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule